// File: doc/BRIEF.md
# Switch Snapshot Register with Live/Stored View Select

This block holds one byte taken from a bank of switches and lets a viewer choose between watching the switches directly or seeing the byte that was last saved. Everything runs on the 100 MHz system clock. The save button never clocks anything: it is brought into the clock domain through a two-stage synchroniser and turned into a one-cycle enable, so each press saves exactly once. The view-select button is synchronised the same way and steers a 2:1 selector in front of the display outputs.

A small two-state machine makes the single-cycle pulse from the save button. Its states are `WAIT_PRESS` (button seen released) and `WAIT_RELEASE` (a press has already been acted on). The transition `PRESS_SEEN` moves from `WAIT_PRESS` to `WAIT_RELEASE` when the synchronised button reads high and raises the save enable for that one cycle. The transition `RELEASE_SEEN` moves back to `WAIT_PRESS` when the synchronised button reads low. In any other case the state holds. Reset is synchronous and active high. It puts the machine in `WAIT_PRESS`, clears both synchronisers and clears the saved byte.

Top module: `store_recall_reg`

## Requirements
- R1: A cycle with `rst` high clears the saved byte to 8'h00. With view select high after reset, `disp_out` shows 8'h00.
- R2: While the synchronised view select is 0, `disp_out` equals `sw_in` in the same cycle, with no register in the path.
- R3: If `btn_load` rises and is sampled high at clock edge k, the saved byte takes the `sw_in` value present at edge k+2. The stored value is first visible after that edge.
- R4: A press held for any number of cycles saves only once. Switch changes during the hold leave the saved byte unchanged.
- R5: A new save needs the synchronised button to be seen low at least once (`RELEASE_SEEN`) before it is seen high again (`PRESS_SEEN`).
- R6: While the synchronised view select is 1, `disp_out` equals the saved byte. A change on `btn_recall` sampled at edge k reaches `disp_out` after edge k+1.
- R7: Without a save enable, the saved byte does not change, whatever `sw_in` does.
- R8: A save made while the stored view is selected shows the new byte on `disp_out` right after the capturing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz system clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_in | input | 8 | Live switch byte |
| btn_load | input | 1 | Save button, asynchronous level |
| btn_recall | input | 1 | View select button, asynchronous level (1 = stored byte) |
| disp_out | output | 8 | Byte shown on the display |

## Verification
The assertions assume that reset is asserted from the first clock edge. They also assume that `btn_load`, `btn_recall` and `sw_in` change away from clock edges, so that each edge samples one settled value. The checker follows the button levels through its own history registers, and it only applies the view and pulse properties once enough cycles have passed since reset to fill the synchroniser. The stimulus changes every input 2 ns after a rising edge. It asserts reset at time zero, and it keeps the save button low while a mid-run reset is applied.

// File: rtl/sr_pkg.sv
package sr_pkg;

    // Save-button press tracker states
    typedef enum logic [0:0] {
        WAIT_PRESS   = 1'b0,
        WAIT_RELEASE = 1'b1
    } press_state_e;

    // Index of each control line inside the synchronised control bus
    localparam int unsigned CTL_LOAD   = 0;
    localparam int unsigned CTL_RECALL = 1;
    localparam int unsigned CTL_COUNT  = 2;

endpackage

// File: rtl/sr_sync.sv
module sr_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_out = chain_q[LAST];

endmodule

// File: rtl/sr_press_fsm.sv
module sr_press_fsm
    import sr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic level_in,
    output logic pulse_out
);

    press_state_e state_q;
    press_state_e state_d;

    // Next-state logic: PRESS_SEEN and RELEASE_SEEN transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WAIT_PRESS:   if (level_in)  state_d = WAIT_RELEASE;
            WAIT_RELEASE: if (!level_in) state_d = WAIT_PRESS;
            default:      state_d = WAIT_PRESS;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WAIT_PRESS;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode: one-cycle enable on PRESS_SEEN
    always_comb begin
        pulse_out = 1'b0;
        unique case (state_q)
            WAIT_PRESS:   pulse_out = level_in;
            WAIT_RELEASE: pulse_out = 1'b0;
            default:      pulse_out = 1'b0;
        endcase
    end

endmodule

// File: rtl/sr_capture_reg.sv
module sr_capture_reg #(
    parameter int unsigned          WIDTH     = 8,
    parameter logic [WIDTH-1:0]     RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_out <= RESET_VAL;
        end else if (load_en) begin
            q_out <= d_in;
        end
    end

endmodule

// File: rtl/sr_view_mux.sv
module sr_view_mux #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             pick_stored,
    input  logic [WIDTH-1:0] live_in,
    input  logic [WIDTH-1:0] stored_in,
    output logic [WIDTH-1:0] view_out
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign view_out[b] = pick_stored ? stored_in[b] : live_in[b];
    end

endmodule

// File: rtl/store_recall_reg.sv
module store_recall_reg
    import sr_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] sw_in,
    input  logic              btn_load,
    input  logic              btn_recall,
    output logic [DATA_W-1:0] disp_out
);

    localparam logic [DATA_W-1:0] CLEAR_VAL = '0;

    logic [CTL_COUNT-1:0] ctl_async;
    logic [CTL_COUNT-1:0] ctl_sync;
    logic                 load_pulse;
    logic                 recall_sel;
    logic [DATA_W-1:0]    stored_q;

    always_comb begin
        ctl_async             = '0;
        ctl_async[CTL_LOAD]   = btn_load;
        ctl_async[CTL_RECALL] = btn_recall;
    end

    sr_sync #(
        .WIDTH  (CTL_COUNT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (ctl_async),
        .sync_out (ctl_sync)
    );

    assign recall_sel = ctl_sync[CTL_RECALL];

    sr_press_fsm u_press (
        .clk       (clk),
        .rst       (rst),
        .level_in  (ctl_sync[CTL_LOAD]),
        .pulse_out (load_pulse)
    );

    sr_capture_reg #(
        .WIDTH     (DATA_W),
        .RESET_VAL (CLEAR_VAL)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .load_en (load_pulse),
        .d_in    (sw_in),
        .q_out   (stored_q)
    );

    sr_view_mux #(
        .WIDTH (DATA_W)
    ) u_view (
        .pick_stored (recall_sel),
        .live_in     (sw_in),
        .stored_in   (stored_q),
        .view_out    (disp_out)
    );

endmodule

// File: rtl/sr_checker.sv
module sr_checker #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] sw_in,
    input logic              btn_load,
    input logic              btn_recall,
    input logic [DATA_W-1:0] disp_out,
    input logic              load_pulse,
    input logic [DATA_W-1:0] stored_q
);

    localparam int unsigned CW = $clog2(SYNC_STAGES + 1) + 1;

    logic [CW-1:0]          warm_q;
    logic                   warm;
    logic                   rst_seen_q;
    logic [SYNC_STAGES-1:0] load_hist_q;
    logic [SYNC_STAGES-1:0] recall_hist_q;

    always_ff @(posedge clk) begin
        rst_seen_q    <= rst;
        load_hist_q   <= {load_hist_q[SYNC_STAGES-2:0], btn_load};
        recall_hist_q <= {recall_hist_q[SYNC_STAGES-2:0], btn_recall};
        if (rst) begin
            warm_q <= '0;
        end else if (warm_q < CW'(SYNC_STAGES)) begin
            warm_q <= warm_q + 1'b1;
        end
    end

    assign warm = (warm_q >= CW'(SYNC_STAGES));

    // R1: a reset cycle leaves the stored byte cleared
    always_ff @(posedge clk) begin
        if (rst_seen_q) begin
            assert_reset_clear_R1: assert (stored_q == '0)
                else $error("stored byte not cleared after reset");
        end
    end

    // R2: live view follows the switches
    assert_live_view_R2: assert property (@(posedge clk) disable iff (rst)
        (warm && !recall_hist_q[SYNC_STAGES-1]) |-> (disp_out == sw_in));

    // R3: an enable captures the switch byte of that edge
    assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
        load_pulse |=> (stored_q == $past(sw_in)));

    // R4: the enable lasts a single cycle
    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        load_pulse |=> !load_pulse);

    // R5: an enable only follows a button that reads pressed
    assert_pulse_needs_press_R5: assert property (@(posedge clk) disable iff (rst)
        (warm && load_pulse) |-> load_hist_q[SYNC_STAGES-1]);

    // R6: stored view shows the saved byte
    assert_stored_view_R6: assert property (@(posedge clk) disable iff (rst)
        (warm && recall_hist_q[SYNC_STAGES-1]) |-> (disp_out == stored_q));

    // R7: no enable, no change
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !load_pulse |=> $stable(stored_q));

endmodule

bind store_recall_reg sr_checker #(
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sw_in      (sw_in),
    .btn_load   (btn_load),
    .btn_recall (btn_recall),
    .disp_out   (disp_out),
    .load_pulse (load_pulse),
    .stored_q   (stored_q)
);

// File: tb/store_recall_reg_bench.sv
module store_recall_reg_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] sw_in;
    logic       btn_load;
    logic       btn_recall;
    logic [7:0] disp_out;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    string      tag_q[$];
    logic [7:0] exp_q[$];
    event       chk_ev;

    always #5 clk = ~clk;

    store_recall_reg u_store_recall_reg (
        .clk        (clk),
        .rst        (rst),
        .sw_in      (sw_in),
        .btn_load   (btn_load),
        .btn_recall (btn_recall),
        .disp_out   (disp_out)
    );

    // Monitor: pops expected items and compares against the output
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                string      t;
                logic [7:0] e;
                t = tag_q.pop_front();
                e = exp_q.pop_front();
                n_vec++;
                if (disp_out !== e) begin
                    n_fail++;
                    $display("FAIL %s: disp_out=%h expected=%h at %0t", t, disp_out, e, $time);
                end
            end
        end
    end

    // Driver-side scoreboard push
    task automatic expect_disp(input string t, input logic [7:0] e);
        tag_q.push_back(t);
        exp_q.push_back(e);
        -> chk_ev;
        #1;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; sw_in = 8'h00; btn_load = 1'b0; btn_recall = 1'b0;
        step(3);
        rst = 1'b0;

        // R1: stored view right after reset shows zero
        sw_in = 8'hE7;
        btn_recall = 1'b1;
        step(2);
        expect_disp("R1", 8'h00);

        // R2: live view is combinational
        btn_recall = 1'b0;
        step(2);
        sw_in = 8'hA5; #1;
        expect_disp("R2", 8'hA5);
        sw_in = 8'h3C; #1;
        expect_disp("R2", 8'h3C);

        // R3: capture lands two edges after the sampling edge
        btn_recall = 1'b1;
        step(2);
        expect_disp("R6", 8'h00);
        sw_in = 8'h5A;
        btn_load = 1'b1;
        step(1);
        expect_disp("R3", 8'h00);
        step(1);
        expect_disp("R3", 8'h00);
        step(1);
        expect_disp("R3", 8'h5A);

        // R4: holding the button saves once only
        sw_in = 8'hFF;
        for (int i = 0; i < 4; i++) begin
            step(1);
            expect_disp("R4", 8'h5A);
        end

        // R5: release then press again saves a new byte
        btn_load = 1'b0;
        step(3);
        expect_disp("R5", 8'h5A);
        sw_in = 8'h0F;
        btn_load = 1'b1;
        step(3);
        expect_disp("R5", 8'h0F);
        btn_load = 1'b0;
        step(3);

        // R6: view select latency both ways
        sw_in = 8'hC3;
        btn_recall = 1'b0;
        step(1);
        expect_disp("R6", 8'h0F);
        step(1);
        expect_disp("R6", 8'hC3);
        btn_recall = 1'b1;
        step(1);
        expect_disp("R6", 8'hC3);
        step(1);
        expect_disp("R6", 8'h0F);

        // R7: switch activity without a press leaves the byte alone
        for (int i = 0; i < 4; i++) begin
            sw_in = 8'(8'h11 * (i + 3));
            step(1);
            expect_disp("R7", 8'h0F);
        end

        // R8: save while stored view is selected updates right after capture
        sw_in = 8'h96;
        btn_load = 1'b1;
        step(2);
        expect_disp("R8", 8'h0F);
        step(1);
        expect_disp("R8", 8'h96);
        btn_load = 1'b0;
        step(3);

        // R1: mid-run reset clears the saved byte
        rst = 1'b1;
        sw_in = 8'h42;
        step(1);
        expect_disp("R1", 8'h42);
        rst = 1'b0;
        step(2);
        expect_disp("R1", 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule